// File: doc/BRIEF.md
# Field-Synchronized Packet List Inserter

This block walks a chain of packets in memory and injects each packet's payload into a video output stream. Every packet begins with a two-word header. The first word points to the next packet and the second word is a control word. The control word can hold the packet back until a chosen field ID and a chosen screen line come around. After that the payload is either streamed out one byte per cycle, or, for programming packets, turned into register writes.

Software writes a chain of packets into memory and pulses `start` with the address of the first one. The block fetches the header and waits as the control word asks. It then sends the payload, pulses an optional interrupt, and follows the link. A link of zero ends the chain. A failed memory read abandons the chain and leaves an error flag set.

Top module: `pkt_inserter`

## Requirements
- R1: After reset `out_valid`, `irq`, `mem_req`, `reg_wr` and `err` are all low.
- R2: A packet at byte address A has its link word at A and its control word at A+4. The payload starts at A+8. In the control word, bits 12:0 are the payload byte count, and bit 13 has no effect on any output.
- R3: A data packet (control bit 31 = 0) sends its payload on `out_byte` with `out_valid`, in address order. Within each 32-bit word the bytes go out from bits 7:0 upward.
- R4: With control bit 14 = 0 the packet is sent regardless of `field_id`.
- R5: With control bit 14 = 1 the block waits for a rising edge of `vsync` at which `field_id` equals control bits 30:28. Setting bit 14 on each packet of a chain therefore puts each packet in a later field.
- R6: Control bits 27:16 name a screen line, and sending starts only while `line_cnt` equals it. If that line has already passed, the same line of a later field is used. The value 0xFFF removes the line condition.
- R7: With control bit 15 = 1, `irq` pulses high for exactly one cycle after the last payload byte or register write, and also for a packet of zero length. With bit 15 = 0 there is no pulse.
- R8: A non-zero link word makes the block fetch the packet at that address next. A zero link word returns the block to idle. A `start` pulse while a chain is active is ignored.
- R9: With control bit 31 = 1 the payload is read as pairs of words, address first and then data. Each pair produces one `reg_wr` pulse and no `out_valid`.
- R10: A read answered with `mem_err` stops the chain. `err` then stays high until the next accepted `start` clears it.
- R11: At most one memory read is outstanding at a time, so `mem_req` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking the chain at `start_ptr` (idle only) |
| start_ptr | input | ADDR_W | Byte address of the first packet |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of the word read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| mem_err | input | 1 | Read failed (qualified by `mem_rvalid`) |
| vsync | input | 1 | Vertical sync; rising edge starts a field |
| line_cnt | input | 12 | Current screen line, 0 after the `vsync` rise |
| field_id | input | 3 | Current field identifier |
| out_byte | output | 8 | Payload byte |
| out_valid | output | 1 | `out_byte` holds a payload byte this cycle |
| irq | output | 1 | One-cycle packet-done interrupt |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 32 | Register write address |
| reg_data | output | 32 | Register write data |
| err | output | 1 | Sticky memory-error flag |

## Verification
The bench builds the block with `ADDR_W = 12`. It gives the block a 1 KB memory in which any read at or above byte 0x400 returns an error, so a link word can be aimed at a failing address. The video timing model uses short lines of 32 cycles and ten lines per field. This brings several field changes, line matches, missed lines that wrap into the next field, and chains spread across fields within a few thousand cycles. The first byte of each packet is compared against the line and field the bench expects for it.

// File: rtl/pkt_ins_pkg.sv
package pkt_ins_pkg;
  localparam int CNT_W  = 13;
  localparam int LINE_W = 12;
  localparam int FID_W  = 3;
  localparam logic [LINE_W-1:0] LINE_ANY = '1;

  // control word, MSB first
  typedef struct packed {
    logic              prog;
    logic [FID_W-1:0]  fid;
    logic [LINE_W-1:0] line;
    logic              irq_en;
    logic              fwait;
    logic              spare;
    logic [CNT_W-1:0]  cnt;
  } pkt_ctrl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_SYNC, ST_EMIT, ST_IRQ} st_t;
  typedef enum logic [1:0] {PH_LINK, PH_CTRL, PH_DATA} ph_t;

  function automatic pkt_ctrl_t decode_ctrl(input logic [31:0] w);
    return pkt_ctrl_t'(w);
  endfunction

  // bytes of the current word still belonging to the payload
  function automatic logic [2:0] word_take(input logic [CNT_W-1:0] left);
    return (left >= CNT_W'(4)) ? 3'd4 : left[2:0];
  endfunction

  // payload left after consuming one whole word
  function automatic logic [CNT_W-1:0] after_word(input logic [CNT_W-1:0] left);
    return (left > CNT_W'(4)) ? left - CNT_W'(4) : '0;
  endfunction
endpackage

// File: rtl/pkt_sync_gate.sv
module pkt_sync_gate
  import pkt_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              need_field,
  input  logic [FID_W-1:0]  tgt_fid,
  input  logic [LINE_W-1:0] tgt_line,
  input  logic              vsync,
  input  logic [FID_W-1:0]  field_id,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              go
);
  logic vs_d, field_ok;
  logic vs_rise, fid_hit, line_hit;

  assign vs_rise  = vsync & ~vs_d;
  assign fid_hit  = vs_rise && (field_id == tgt_fid);
  assign line_hit = (tgt_line == LINE_ANY) || (line_cnt == tgt_line);
  assign go       = field_ok && line_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d     <= 1'b0;
      field_ok <= 1'b0;
    end else begin
      vs_d <= vsync;
      if (arm)          field_ok <= !need_field || fid_hit;
      else if (fid_hit) field_ok <= 1'b1;
    end
  end

  // R5
  field_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !field_ok) |=> (!field_ok || $past(vs_rise)));
endmodule

// File: rtl/pkt_byte_shift.sv
module pkt_byte_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        shift,
  input  logic [31:0] word,
  output logic [7:0]  byte_out
);
  logic [31:0] sh;
  assign byte_out = sh[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= word;
    else if (shift) sh <= {8'h00, sh[31:8]};
  end
endmodule

// File: rtl/pkt_inserter.sv
module pkt_inserter
  import pkt_ins_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_ptr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  input  logic              vsync,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [FID_W-1:0]  field_id,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq,
  output logic              reg_wr,
  output logic [31:0]       reg_addr,
  output logic [31:0]       reg_data,
  output logic              err
);
  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(4);

  st_t               state;
  ph_t               phase;
  logic              pend, have_addr;
  logic [ADDR_W-1:0] cur_addr, link;
  pkt_ctrl_t         ctrl, ctrl_in, ctrl_view;
  logic [CNT_W-1:0]  remain;
  logic [2:0]        bleft;
  logic [31:0]       addr_hold;

  // named internal events
  logic rd_done, rd_ok, rd_bad, arm, go, load_word, emit;
  assign rd_done   = (state == ST_FETCH) && pend && mem_rvalid;
  assign rd_ok     = rd_done && !mem_err;
  assign rd_bad    = rd_done && mem_err;
  assign ctrl_in   = decode_ctrl(mem_rdata);
  assign arm       = rd_ok && (phase == PH_CTRL);
  assign ctrl_view = arm ? ctrl_in : ctrl;
  assign load_word = rd_ok && (phase == PH_DATA) && !ctrl.prog;
  assign emit      = (state == ST_EMIT);

  assign mem_req   = (state == ST_FETCH) && !pend;
  assign mem_addr  = cur_addr;
  assign out_valid = emit;
  assign irq       = (state == ST_IRQ) && ctrl.irq_en;
  assign reg_wr    = rd_ok && (phase == PH_DATA) && ctrl.prog && have_addr;
  assign reg_addr  = addr_hold;
  assign reg_data  = mem_rdata;

  pkt_sync_gate u_gate (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .need_field(ctrl_view.fwait), .tgt_fid(ctrl_view.fid), .tgt_line(ctrl_view.line),
    .vsync(vsync), .field_id(field_id), .line_cnt(line_cnt), .go(go)
  );

  pkt_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_word), .shift(emit),
    .word(mem_rdata), .byte_out(out_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_LINK;
      pend      <= 1'b0;
      have_addr <= 1'b0;
      cur_addr  <= '0;
      link      <= '0;
      ctrl      <= '0;
      remain    <= '0;
      bleft     <= '0;
      addr_hold <= '0;
      err       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur_addr <= start_ptr;
          phase    <= PH_LINK;
          pend     <= 1'b0;
          err      <= 1'b0;
          state    <= ST_FETCH;
        end
        ST_FETCH: begin
          if (mem_req) pend <= 1'b1;
          if (rd_bad) begin
            pend  <= 1'b0;
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (rd_ok) begin
            pend     <= 1'b0;
            cur_addr <= cur_addr + WSTEP;
            unique case (phase)
              PH_LINK: begin
                link  <= mem_rdata[ADDR_W-1:0];
                phase <= PH_CTRL;
              end
              PH_CTRL: begin
                ctrl      <= ctrl_in;
                remain    <= ctrl_in.cnt;
                have_addr <= 1'b0;
                state     <= ST_SYNC;
              end
              default: begin
                if (ctrl.prog) begin
                  remain    <= after_word(remain);
                  have_addr <= !have_addr;
                  if (!have_addr) addr_hold <= mem_rdata;
                  if (remain <= CNT_W'(4)) state <= ST_IRQ;
                end else begin
                  bleft <= word_take(remain);
                  state <= ST_EMIT;
                end
              end
            endcase
          end
        end
        ST_SYNC: if (go) begin
          phase <= PH_DATA;
          state <= (remain == '0) ? ST_IRQ : ST_FETCH;
        end
        ST_EMIT: begin
          remain <= remain - CNT_W'(1);
          bleft  <= bleft - 3'd1;
          if (remain == CNT_W'(1)) state <= ST_IRQ;
          else if (bleft == 3'd1)  state <= ST_FETCH;
        end
        default: begin
          if (link == '0) state <= ST_IDLE;
          else begin
            cur_addr <= link;
            phase    <= PH_LINK;
            state    <= ST_FETCH;
          end
        end
      endcase
    end
  end

  // R3
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && reg_wr));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R11
  one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !reg_wr && !mem_req));
  // R9
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !out_valid);
endmodule

// File: tb/pkt_inserter_test.sv
`timescale 1ns/1ps
module pkt_inserter_test;
  localparam int AW = 12;
  localparam int LINE_CYC = 32;
  localparam int NLINES = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_ptr = '0;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic mem_err = 1'b0;
  logic vsync;
  logic [11:0] line_cnt = '0;
  logic [2:0] field_id = '0;
  logic [7:0] out_byte;
  logic out_valid, irq, reg_wr, err;
  logic [31:0] reg_addr, reg_data;

  always #5 clk = ~clk;

  pkt_inserter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .vsync(vsync),
    .line_cnt(line_cnt), .field_id(field_id), .out_byte(out_byte),
    .out_valid(out_valid), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .err(err)
  );

  // memory: 256 words, error at or above 0x400
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (mem_req) begin
      mem_rvalid <= 1'b1;
      if (mem_addr >= AW'(12'h400)) begin
        mem_err   <= 1'b1;
        mem_rdata <= '0;
      end else mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  // video timing model
  int pix = 0;
  always @(posedge clk) begin
    if (pix == LINE_CYC-1) begin
      pix <= 0;
      if (line_cnt == 12'(NLINES-1)) begin
        line_cnt <= '0;
        field_id <= field_id + 3'd1;
      end else line_cnt <= line_cnt + 12'd1;
    end else pix <= pix + 1;
  end
  assign vsync = (line_cnt == 12'd0) && (pix < 4);

  // scoreboard
  typedef struct { logic [7:0] b; int line; int fid; string req; } exp_t;
  exp_t byte_q[$];
  logic [63:0] reg_q[$];
  int total = 0, bad = 0, irq_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (irq) irq_seen++;
    if (out_valid) begin
      if (byte_q.size() == 0) chk(0, "R8 unexpected byte", {56'd0, out_byte}, 64'd0);
      else begin
        exp_t e;
        e = byte_q.pop_front();
        chk(out_byte == e.b, {e.req, " byte"}, {56'd0, out_byte}, {56'd0, e.b});
        if (e.line >= 0) chk(int'(line_cnt) == e.line, "R6 line", 64'(line_cnt), 64'(e.line));
        if (e.fid >= 0) chk(int'(field_id) == e.fid, "R5 field", 64'(field_id), 64'(e.fid));
      end
    end
    if (reg_wr) begin
      if (reg_q.size() == 0) chk(0, "R9 unexpected write", {reg_addr, reg_data}, 64'd0);
      else begin
        logic [63:0] r;
        r = reg_q.pop_front();
        chk({reg_addr, reg_data} == r, "R9 write", {reg_addr, reg_data}, r);
      end
    end
  end

  function automatic logic [31:0] mk_ctrl(bit prog, int fid, int line, bit ien, bit fw, bit b13, int cnt);
    return {prog, 3'(fid), 12'(line), ien, fw, b13, 13'(cnt)};
  endfunction

  // driver: write a data packet into memory, push its expected bytes
  task automatic put_data(input int base, input int link, input int cnt, input bit fw, input int fid,
                          input int line, input bit ien, input bit b13, input int seed,
                          input int xline, input int xfid, input string req);
    mem[base>>2]     = 32'(link);
    mem[(base>>2)+1] = mk_ctrl(0, fid, line, ien, fw, b13, cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_t e;
      e.b = 8'(seed + 7*k);
      mem[(base+8+k)>>2][8*(k%4) +: 8] = e.b;
      e.line = (k == 0) ? xline : -1;
      e.fid  = (k == 0) ? xfid : -1;
      e.req  = req;
      byte_q.push_back(e);
    end
  endtask

  task automatic kick(input int addr);
    @(negedge clk);
    start <= 1'b1;
    start_ptr <= AW'(addr);
    @(negedge clk);
    start <= 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((byte_q.size() != 0 || reg_q.size() != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, {req, " completion"}, 64'(byte_q.size() + reg_q.size()), 64'd0);
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_line(input int l);
    do @(negedge clk); while (!(int'(line_cnt) == l && pix == 1));
  endtask

  initial begin
    int tgt;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!out_valid && !irq && !mem_req && !reg_wr && !err, "R1 reset",
        {59'd0, out_valid, irq, mem_req, reg_wr, err}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: single packet, spare bit 13 set, irq requested
    irq_seen = 0;
    put_data('h000, 0, 6, 0, 5, 'hFFF, 1, 1, 'h11, -1, -1, "R2 R3");
    kick('h000);
    drain("R3");
    chk(irq_seen == 1, "R7 irq count", 64'(irq_seen), 64'd1);

    // R4 R5 R8: chain, field wait on first only -> all in one field
    irq_seen = 0;
    tgt = (int'(field_id) + 2) % 8;
    put_data('h040, 'h080, 5, 1, tgt, 'hFFF, 0, 0, 'h20, 0, tgt, "R5");
    put_data('h080, 'h0C0, 3, 0, (tgt+3)%8, 'hFFF, 1, 0, 'h40, -1, tgt, "R4");
    put_data('h0C0, 0, 4, 0, (tgt+5)%8, 'hFFF, 1, 0, 'h60, -1, tgt, "R8");
    kick('h040);
    drain("R8");
    chk(irq_seen == 2, "R7 irq count chain", 64'(irq_seen), 64'd2);

    // R5: field wait on every packet spreads them across fields
    tgt = (int'(field_id) + 2) % 8;
    put_data('h100, 'h140, 2, 1, tgt, 'hFFF, 0, 0, 'h70, 0, tgt, "R5 spread");
    put_data('h140, 0, 2, 1, (tgt+1)%8, 'hFFF, 0, 0, 'h90, 0, (tgt+1)%8, "R5 spread");
    kick('h100);
    drain("R5");

    // R6 + R8: field and line 5; second start while active ignored
    irq_seen = 0;
    tgt = (int'(field_id) + 2) % 8;
    put_data('h180, 0, 7, 1, tgt, 5, 1, 0, 'hA0, 5, tgt, "R6");
    kick('h180);
    repeat (20) @(negedge clk);
    kick('h000);
    drain("R6");
    chk(irq_seen == 1, "R8 start ignored irq count", 64'(irq_seen), 64'd1);

    // R6: target line already passed -> next field's line 3
    wait_line(7);
    tgt = (int'(field_id) + 1) % 8;
    put_data('h1C0, 0, 4, 0, 0, 3, 0, 0, 'hB3, 3, tgt, "R6 wrap");
    kick('h1C0);
    drain("R6 wrap");

    // R9: programming packet, two writes, no bytes
    irq_seen = 0;
    mem['h200>>2] = 0;
    mem[('h200>>2)+1] = mk_ctrl(1, 0, 'hFFF, 1, 0, 0, 16);
    mem[('h200>>2)+2] = 32'h1234_0000;
    mem[('h200>>2)+3] = 32'hCAFE_0001;
    mem[('h200>>2)+4] = 32'h1234_0004;
    mem[('h200>>2)+5] = 32'h0BAD_F00D;
    reg_q.push_back({32'h1234_0000, 32'hCAFE_0001});
    reg_q.push_back({32'h1234_0004, 32'h0BAD_F00D});
    kick('h200);
    drain("R9");
    chk(irq_seen == 1, "R7 irq after writes", 64'(irq_seen), 64'd1);

    // R7: no interrupt when bit 15 clear, 9 bytes over three words
    irq_seen = 0;
    put_data('h240, 0, 9, 0, 0, 'hFFF, 0, 0, 'hC5, -1, -1, "R3 R7");
    kick('h240);
    drain("R7");
    chk(irq_seen == 0, "R7 no irq", 64'(irq_seen), 64'd0);

    // R7: zero-length packet still interrupts
    irq_seen = 0;
    mem['h280>>2] = 0;
    mem[('h280>>2)+1] = mk_ctrl(0, 0, 'hFFF, 1, 0, 0, 0);
    kick('h280);
    repeat (40) @(negedge clk);
    chk(irq_seen == 1, "R7 zero length irq", 64'(irq_seen), 64'd1);

    // R10: link into failing region aborts and sets err
    put_data('h2C0, 'h500, 3, 0, 0, 'hFFF, 0, 0, 'hD1, -1, -1, "R10");
    kick('h2C0);
    drain("R10");
    repeat (30) @(negedge clk);
    chk(err == 1'b1, "R10 err set", 64'(err), 64'd1);
    chk(!mem_req, "R10 idle after error", 64'(mem_req), 64'd0);

    // R10: next start clears err and runs normally
    put_data('h000, 0, 6, 0, 5, 'hFFF, 1, 1, 'h11, -1, -1, "R10 restart");
    kick('h000);
    chk(err == 1'b0, "R10 err cleared", 64'(err), 64'd0);
    drain("R10 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule